// File: doc/BRIEF.md
# Serial Host Interrupt Aggregator

This block gathers the fault pulses and status levels of a serial host controller's datapath and turns them into two interrupt lines: one for faults and one for events. Fault pulses land in a sticky fault register. A per-cause mask selects which of those faults may raise the fault interrupt. A separate mask selects which datapath levels (ready, transmit queue empty, receive queue full) may raise the event interrupt.

Each interrupt class has a pending bit. The pending bit is set when the class is enabled, is not already pending, and either a selected cause is present or software has written the class's test bit. It stays set until software writes 1 to it. The interrupt pin is a flop holding the AND of the pending bit and the class enable. All registers sit behind a small word-addressed write/read port, with a combinational read. A synchronous soft-reset input clears the pending bits and the fault register.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset, the registers read back as follows: pending (address 0) 0, class enable (address 1) 0, test (address 2) 0, fault mask (address 3) 0x1F, fault register (address 4) 0, event mask (address 5) 0. Both interrupt outputs are low.
- R2: A high on `fault_in` bit i during a clock edge sets bit i of the fault register at that edge. The bit stays set until it is cleared. Bit meanings: 0 command while busy, 1 transmit overflow, 2 receive underflow, 3 bad command, 4 bad chip select, 5 bad access.
- R3: Writing 1s to address 4 clears those fault bits. A fault pulse arriving in the same cycle as the clear wins, and the bit stays set.
- R4: Pending bit 0 (fault class) is set when class enable bit 0 is 1, pending bit 0 is 0, and fault register bits 0, 3 or 4 are set with the matching fault-mask bit. Fault bits 1, 2 and 5 never raise it.
- R5: Pending bit 1 (event class) is set when class enable bit 1 is 1, pending bit 1 is 0, and an active level is selected by the event mask: bit 0 receive full, bit 1 transmit empty, bit 4 ready. Event mask bits 2, 3 and 5 are stored but have no effect.
- R6: Writing to address 2 with bit 0 or bit 1 set raises the matching class once, in that write's clock edge, if the class is enabled and not pending. The test bits are not stored and read back as 0.
- R7: A pending bit stays set until software writes 1 to that bit at address 0.
- R8: `irq_fault` and `irq_event` equal, one cycle later, the AND of the class's pending bit and its class enable bit.
- R9: `soft_rst` clears the pending bits and the fault register at the next edge. The enable and mask registers are left as they are.
- R10: With class enable bit 0 at 0, fault causes leave pending bit 0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of pending bits and fault register |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| fault_in | input | 6 | Fault pulses from the datapath |
| dp_ready | input | 1 | Datapath ready for a command |
| dp_tx_empty | input | 1 | Transmit queue empty |
| dp_rx_full | input | 1 | Receive queue full |
| irq_fault | output | 1 | Fault interrupt line |
| irq_event | output | 1 | Event interrupt line |

## Verification
The hardest case to reach is a fault pulse landing in the same clock as a software clear of that fault bit. The stimulus drives the pulse and the clearing write in one cycle, then reads the bit back as set.

A second hard case is the test trigger leaving nothing behind. The bench fires both classes through the test register, clears the pending bits, and waits several cycles to show that nothing fires again. The non-firing fault causes and the inert event-mask bits are checked with their class enabled, so any leak would show up as a pending bit.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int FAULT_W  = 6;
    localparam int FMASK_W  = 5;
    localparam int EMASK_W  = 6;
    localparam int CLASS_N  = 2;
    localparam int CLS_FAULT = 0;
    localparam int CLS_EVENT = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND   = 3'd0,
        RA_CLSEN  = 3'd1,
        RA_TEST   = 3'd2,
        RA_FMASK  = 3'd3,
        RA_FAULT  = 3'd4,
        RA_EMASK  = 3'd5
    } reg_addr_e;

    // fault bits that may raise the fault class: busy(0), bad cmd(3), bad cs(4)
    localparam logic [FAULT_W-1:0] FAULT_LIVE = 6'b011001;
    // event mask bits wired to a level: rx full(0), tx empty(1), ready(4)
    localparam logic [EMASK_W-1:0] EVENT_LIVE = 6'b010011;
    localparam logic [FMASK_W-1:0] FMASK_RESET = 5'h1F;

    typedef struct packed {
        logic ready;
        logic tx_empty;
        logic rx_full;
    } dp_levels_t;

    function automatic logic [EMASK_W-1:0] level_vec(input dp_levels_t l);
        return {1'b0, l.ready, 2'b00, l.tx_empty, l.rx_full};
    endfunction
endpackage

// File: rtl/spi_irq_fault_track.sv
module spi_irq_fault_track
    import spi_irq_pkg::*;
#(
    parameter int W = FAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) status_q <= '0;
        else                 status_q <= (status_q & ~clr_i) | set_i;
    end

    assign status_o = status_q;

    // R2
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> ((($past(status_q) & ~$past(clr_i)) & ~status_q) == '0));
    // R3
    fault_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> (($past(set_i) & ~status_q) == '0));
    // R9
    fault_soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (status_q == '0));
endmodule

// File: rtl/spi_irq_class.sv
module spi_irq_class (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic enable_i,
    input  logic cause_i,
    input  logic test_i,
    input  logic clr_i,
    output logic state_o,
    output logic irq_o
);
    logic state_q;
    logic irq_q;
    logic fire;

    assign fire = enable_i && !state_q && (test_i || cause_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= state_q & enable_i;
            if (soft_rst) state_q <= 1'b0;
            else          state_q <= (state_q && !clr_i) || fire;
        end
    end

    assign state_o = state_q;
    assign irq_o   = irq_q;

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q && !clr_i && !soft_rst) |=> state_q);
    // R9
    pend_soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !state_q);
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(state_q && enable_i));
    // R10
    pend_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !state_q) |=> !state_q);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [CLASS_N-1:0] cls_en_o,
    output logic [FMASK_W-1:0] fmask_o,
    output logic [EMASK_W-1:0] emask_o,
    output logic [CLASS_N-1:0] pend_clr_o,
    output logic [CLASS_N-1:0] test_o,
    output logic [FAULT_W-1:0] fault_clr_o
);
    logic [CLASS_N-1:0] cls_en_q;
    logic [FMASK_W-1:0] fmask_q;
    logic [EMASK_W-1:0] emask_q;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:8];

    function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a,
                                 input reg_addr_e r);
        return we && (a == r);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_en_q <= '0;
            fmask_q  <= FMASK_RESET;
            emask_q  <= '0;
        end else begin
            if (hit(reg_we, reg_addr, RA_CLSEN)) cls_en_q <= reg_wdata[CLASS_N-1:0];
            if (hit(reg_we, reg_addr, RA_FMASK)) fmask_q  <= reg_wdata[FMASK_W-1:0];
            if (hit(reg_we, reg_addr, RA_EMASK)) emask_q  <= reg_wdata[EMASK_W-1:0];
        end
    end

    always_comb begin
        pend_clr_o  = hit(reg_we, reg_addr, RA_PEND)  ? reg_wdata[CLASS_N-1:0] : '0;
        test_o      = hit(reg_we, reg_addr, RA_TEST)  ? reg_wdata[CLASS_N-1:0] : '0;
        fault_clr_o = hit(reg_we, reg_addr, RA_FAULT) ? reg_wdata[FAULT_W-1:0] : '0;
    end

    assign cls_en_o = cls_en_q;
    assign fmask_o  = fmask_q;
    assign emask_o  = emask_q;

    // R1
    fmask_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (fmask_q == FMASK_RESET && cls_en_q == '0));
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
    import spi_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [FAULT_W-1:0]  fault_in,
    input  logic                dp_ready,
    input  logic                dp_tx_empty,
    input  logic                dp_rx_full,
    output logic                irq_fault,
    output logic                irq_event
);
    logic [CLASS_N-1:0] cls_en;
    logic [FMASK_W-1:0] fmask;
    logic [EMASK_W-1:0] emask;
    logic [CLASS_N-1:0] pend_clr;
    logic [CLASS_N-1:0] test;
    logic [FAULT_W-1:0] fault_clr;
    logic [FAULT_W-1:0] fault_st;
    logic [CLASS_N-1:0] cause;
    logic [CLASS_N-1:0] pend;
    logic [CLASS_N-1:0] irq;
    dp_levels_t         lv;

    spi_irq_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cls_en_o(cls_en), .fmask_o(fmask),
        .emask_o(emask), .pend_clr_o(pend_clr), .test_o(test),
        .fault_clr_o(fault_clr)
    );

    spi_irq_fault_track #(.W(FAULT_W)) u_fault (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .set_i(fault_in), .clr_i(fault_clr), .status_o(fault_st)
    );

    assign lv = '{ready: dp_ready, tx_empty: dp_tx_empty, rx_full: dp_rx_full};

    assign cause[CLS_FAULT] = |({1'b0, fmask} & fault_st & FAULT_LIVE);
    assign cause[CLS_EVENT] = |(emask & level_vec(lv) & EVENT_LIVE);

    for (genvar c = 0; c < CLASS_N; c++) begin : g_cls
        spi_irq_class u_cls (
            .clk(clk), .rst(rst), .soft_rst(soft_rst),
            .enable_i(cls_en[c]), .cause_i(cause[c]), .test_i(test[c]),
            .clr_i(pend_clr[c]), .state_o(pend[c]), .irq_o(irq[c])
        );
    end

    assign irq_fault = irq[CLS_FAULT];
    assign irq_event = irq[CLS_EVENT];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_PEND:  reg_rdata[CLASS_N-1:0] = pend;
            RA_CLSEN: reg_rdata[CLASS_N-1:0] = cls_en;
            RA_FMASK: reg_rdata[FMASK_W-1:0] = fmask;
            RA_FAULT: reg_rdata[FAULT_W-1:0] = fault_st;
            RA_EMASK: reg_rdata[EMASK_W-1:0] = emask;
            default:  reg_rdata = '0;
        endcase
    end

    // R4
    no_quiet_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend[CLS_FAULT] && !test[CLS_FAULT] && ((fault_st & FAULT_LIVE) == '0))
        |=> !pend[CLS_FAULT]);
    // R5
    no_quiet_event_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend[CLS_EVENT] && !test[CLS_EVENT] && ((emask & EVENT_LIVE) == '0))
        |=> !pend[CLS_EVENT]);
endmodule

// File: tb/spi_irq_agg_test.sv
module spi_irq_agg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  fault_in = '0;
    logic        dp_ready = 1'b0;
    logic        dp_tx_empty = 1'b0;
    logic        dp_rx_full = 1'b0;
    logic        irq_fault;
    logic        irq_event;

    int checks = 0;
    int errors = 0;
    bit running = 0;

    // behavioural reference
    bit [1:0] m_pend, m_en, m_irq;
    bit [4:0] m_fmask;
    bit [5:0] m_fault, m_emask;

    always #5 clk = ~clk;

    spi_irq_agg uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_in(fault_in), .dp_ready(dp_ready), .dp_tx_empty(dp_tx_empty),
        .dp_rx_full(dp_rx_full), .irq_fault(irq_fault), .irq_event(irq_event)
    );

    always @(posedge clk) begin
        bit [1:0] clr, tst, fire, np;
        bit [5:0] fclr;
        bit fc, ec;
        if (rst) begin
            m_pend = 0; m_en = 0; m_irq = 0; m_fmask = 5'h1F; m_fault = 0; m_emask = 0;
        end else begin
            clr  = (reg_we && reg_addr == 0) ? reg_wdata[1:0] : 2'b0;
            tst  = (reg_we && reg_addr == 2) ? reg_wdata[1:0] : 2'b0;
            fclr = (reg_we && reg_addr == 4) ? reg_wdata[5:0] : 6'b0;
            fc = (m_fault[0] && m_fmask[0]) || (m_fault[3] && m_fmask[3]) ||
                 (m_fault[4] && m_fmask[4]);
            ec = (m_emask[0] && dp_rx_full) || (m_emask[1] && dp_tx_empty) ||
                 (m_emask[4] && dp_ready);
            fire[0] = m_en[0] && !m_pend[0] && (tst[0] || fc);
            fire[1] = m_en[1] && !m_pend[1] && (tst[1] || ec);
            np = soft_rst ? 2'b0 : ((m_pend & ~clr) | fire);
            m_irq = m_pend & m_en;
            m_fault = soft_rst ? 6'b0 : ((m_fault & ~fclr) | fault_in);
            m_pend = np;
            if (reg_we && reg_addr == 1) m_en = reg_wdata[1:0];
            if (reg_we && reg_addr == 3) m_fmask = reg_wdata[4:0];
            if (reg_we && reg_addr == 5) m_emask = reg_wdata[5:0];
        end
    end

    // R8: every-cycle comparison of both interrupt pins with the model
    always @(negedge clk) begin
        if (running) begin
            checks++;
            if (irq_fault !== m_irq[0] || irq_event !== m_irq[1]) begin
                errors++;
                $display("FAIL R8 irq pins actual %b%b expected %b%b",
                         irq_event, irq_fault, m_irq[1], m_irq[0]);
            end
        end
    end

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic pulse(input bit [5:0] f);
        @(negedge clk);
        fault_in = f;
        @(negedge clk);
        fault_in = 0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input bit [2:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic pin(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        // R1 reset state
        rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1");
        rd(3, 32'h1F, "R1"); rd(4, 0, "R1"); rd(5, 0, "R1");
        pin(irq_fault, 0, "R1"); pin(irq_event, 0, "R1");

        wr(1, 1);
        pulse(6'h02); waitc(3);
        rd(4, 32'h02, "R2");
        rd(0, 0, "R4 overflow must not fire");
        pulse(6'h01); waitc(3);
        rd(4, 32'h03, "R2");
        rd(0, 1, "R4");
        pin(irq_fault, 1, "R8");

        wr(4, 3);
        rd(4, 0, "R3");
        rd(0, 1, "R7 pending held");
        wr(0, 1); waitc(2);
        rd(0, 0, "R7 cleared");
        pin(irq_fault, 0, "R8");

        wr(1, 0);
        pulse(6'h08); waitc(3);
        rd(0, 0, "R10");
        wr(1, 1); waitc(2);
        rd(0, 1, "R4 late enable");

        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
        rd(0, 0, "R9"); rd(4, 0, "R9"); rd(1, 1, "R9 enable kept");

        wr(1, 0);
        dp_ready = 1; dp_tx_empty = 1; dp_rx_full = 1;
        wr(5, 32'h2C); wr(1, 2); waitc(3);
        rd(0, 0, "R5 inert mask bits");
        rd(5, 32'h2C, "R5");
        wr(5, 32'h10); waitc(3);
        rd(0, 2, "R5 ready");
        dp_ready = 0;
        wr(5, 0); wr(0, 2); waitc(2);
        rd(0, 0, "R7");
        wr(5, 32'h01); waitc(3);
        rd(0, 2, "R5 rx full");
        wr(5, 0); wr(0, 2); waitc(2);
        wr(5, 32'h02); waitc(3);
        rd(0, 2, "R5 tx empty");
        wr(5, 0); wr(0, 2);
        dp_tx_empty = 0; dp_rx_full = 0;

        wr(1, 3);
        wr(2, 3); waitc(1);
        rd(0, 3, "R6 test fire");
        rd(2, 0, "R6 test reads zero");
        wr(0, 3); waitc(3);
        rd(0, 0, "R6 no refire");

        @(negedge clk);
        fault_in = 6'h04; reg_we = 1; reg_addr = 4; reg_wdata = 32'h04;
        @(negedge clk);
        fault_in = 0; reg_we = 0; reg_wdata = 0;
        rd(4, 32'h04, "R3 set wins");
        waitc(3);
        rd(0, 0, "R4 underflow must not fire");
        pulse(6'h20); waitc(3);
        rd(4, 32'h24, "R2 access bit");
        rd(0, 0, "R4 access must not fire");

        waitc(3);
        running = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule